// File: doc/BRIEF.md
# Half-Full Triggered Ping-Pong Buffer Loader

This block drains a deep acquisition FIFO into two alternating destination buffers. It waits in idle until readout is enabled and the FIFO signals that it is at least half full. It then runs a self-paced burst of reads that needs no help from the consumer. Each word it reads is written, unmodified, into the buffer that is currently filling, at the next address of that buffer. The data stream carries no special meaning for the block, so a trigger or encoder channel is stored exactly like any other sample.

A burst moves half the FIFO's depth: twice the size of one buffer. When a buffer takes its last word, the block raises a one-cycle ready strobe with that buffer's index, marks the buffer as held, and goes on into the other buffer. The consumer hands a buffer back through a release input. If the block begins filling a buffer that the consumer still holds, a sticky overrun flag is set. A burst ends early when the FIFO runs empty, or when readout is disabled. In either case the fill position is kept, so the next burst continues where the last one stopped.

Top module: `pingpong_mover`

## Requirements
- R1: After reset, `fifo_rd`, `buf_we`, `rdy_strobe`, `overrun` and both bits of `buf_ready` are 0, and the first word written goes to bank 0, address 0.
- R2: A burst begins only while idle with `rd_en` high and `fifo_half` high; with either low, `fifo_rd` stays low.
- R3: Every word read from the FIFO appears on `buf_wdata` with `buf_we` high one cycle after the read, unchanged in all bits. Addresses within a bank run 0, 1, 2, ... in read order.
- R4: The write of address BUF_WORDS-1 into a bank comes with `rdy_strobe` high and `rdy_bank` equal to that bank. The next word goes to address 0 of the other bank. `rdy_strobe` is never high otherwise.
- R5: A burst that meets no empty FIFO and no disable performs exactly FIFO_DEPTH/2 reads (two full buffers), then stops until the trigger condition is seen again.
- R6: `fifo_rd` is never high while `fifo_empty` is high, and a burst that meets an empty FIFO ends.
- R7: Lowering `rd_en` stops new reads from the next cycle; the word already read is still written. When reads resume, the bank and address continue from where they stopped.
- R8: `buf_ready[b]` becomes 1 the cycle after the ready strobe for bank b, and returns to 0 the cycle after `rel_valid` is high with `rel_bank` = b.
- R9: If the first word of a bank is read while `buf_ready` for that bank is 1 and not being released, `overrun` becomes 1. It stays 1 until `overrun_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Readout enable for half-full triggered bursts |
| fifo_half | input | 1 | FIFO holds at least half its depth |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_data | input | DATA_W | Show-ahead FIFO head word |
| fifo_rd | output | 1 | Pop the FIFO head this cycle |
| buf_we | output | 1 | Buffer write strobe |
| buf_bank | output | 1 | Destination bank of the write |
| buf_addr | output | $clog2(FIFO_DEPTH/4) | Word address inside the bank |
| buf_wdata | output | DATA_W | Word being written |
| rdy_strobe | output | 1 | One-cycle pulse: a bank just became full |
| rdy_bank | output | 1 | Index of the bank that became full |
| buf_ready | output | 2 | Per-bank held-by-consumer flags |
| rel_valid | input | 1 | Consumer releases a bank |
| rel_bank | input | 1 | Bank being released |
| overrun | output | 1 | Sticky: a held bank was re-entered |
| overrun_clr | input | 1 | Clears `overrun` |

## Verification
The embedded properties check, on every cycle, the relations between neighbouring cycles. A write follows each read one cycle later with the read data. The strobe coincides with the last address of a bank. No burst starts without enable and half-full. A burst ends when it meets an empty FIFO or a disable. Held flags and the sticky overrun move as their inputs direct. Only the bench scenarios can show the counted behaviour: exactly two buffers of reads per burst, the bank and address sequence across early stops and resumed bursts, and the overrun caused by re-entering a buffer the consumer never released.

// File: rtl/pp_pkg.sv
// Package: shared defaults and the transfer-state encoding for the ping-pong loader.
package pp_pkg;
    localparam int DEF_FIFO_DEPTH = 16384;
    localparam int DEF_DATA_W     = 16;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } xfer_st_e;
endpackage

// File: rtl/pp_burst_ctrl.sv
// Burst sequencer. Waits for enable plus half-full, then issues up to
// BURST_WORDS show-ahead pops. Assumes the FIFO presents its head word on the
// same cycle as the pop. Ends early on empty or on disable.
module pp_burst_ctrl
    import pp_pkg::*;
#(
    parameter int BURST_WORDS = DEF_FIFO_DEPTH / 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic fifo_half,
    input  logic fifo_empty,
    output logic fifo_rd
);
    localparam int CW = $clog2(BURST_WORDS);
    localparam logic [CW-1:0] LAST = CW'(BURST_WORDS - 1);

    xfer_st_e        st;
    logic [CW-1:0]   cnt;

    // Pop while a burst is open, enabled, and the FIFO has data.
    assign fifo_rd = (st == ST_XFER) && rd_en && !fifo_empty;

    // State and beat counter of the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (rd_en && fifo_half) st <= ST_XFER;
                end
                default: begin
                    if (!rd_en || fifo_empty) st <= ST_IDLE;
                    else if (cnt == LAST)     st <= ST_IDLE;
                    else                      cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // R2: a burst opens only after enable and half-full were seen together
    a_r2_start_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER && $past(st) == ST_IDLE) |-> $past(rd_en && fifo_half));

    // R6: an empty FIFO closes the burst
    a_r6_empty_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER && fifo_empty) |=> (st == ST_IDLE));

    // R7: disable closes the burst, so no pop the cycle after
    a_r7_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> !fifo_rd);
endmodule

// File: rtl/pp_writer.sv
// Buffer writer. Registers each popped word into the active bank at the
// running address and flips banks after BUF_WORDS words. The fill position is
// kept across bursts. Also reports when a bank's first word is popped.
module pp_writer
    import pp_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int BUF_WORDS = DEF_FIFO_DEPTH / 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fifo_rd,
    input  logic [DATA_W-1:0]            fifo_data,
    output logic                         buf_we,
    output logic                         buf_bank,
    output logic [$clog2(BUF_WORDS)-1:0] buf_addr,
    output logic [DATA_W-1:0]            buf_wdata,
    output logic                         rdy_strobe,
    output logic                         rdy_bank,
    output logic                         fill_start,
    output logic                         fill_bank
);
    localparam int AW = $clog2(BUF_WORDS);
    localparam logic [AW-1:0] LAST = AW'(BUF_WORDS - 1);

    logic [AW-1:0] ptr;
    logic          bank;

    // The first pop into a bank is what the overrun check watches.
    assign fill_start = fifo_rd && (ptr == '0);
    assign fill_bank  = bank;

    // Fill position: advance per pop, wrap and swap banks at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            bank <= 1'b0;
        end else if (fifo_rd) begin
            if (ptr == LAST) begin
                ptr  <= '0;
                bank <= ~bank;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    // Write beat and ready strobe, one cycle behind the pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_we     <= 1'b0;
            buf_bank   <= 1'b0;
            buf_addr   <= '0;
            buf_wdata  <= '0;
            rdy_strobe <= 1'b0;
            rdy_bank   <= 1'b0;
        end else begin
            buf_we     <= fifo_rd;
            rdy_strobe <= fifo_rd && (ptr == LAST);
            if (fifo_rd) begin
                buf_bank  <= bank;
                buf_addr  <= ptr;
                buf_wdata <= fifo_data;
                rdy_bank  <= bank;
            end
        end
    end

    // R3: each pop becomes a write one cycle later carrying the popped word
    a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> (buf_we && buf_wdata == $past(fifo_data)));

    // R3: no write without a pop the cycle before
    a_r3_no_spurious_write: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> $past(fifo_rd));

    // R4: the ready strobe rides on the last address of its bank
    a_r4_strobe_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_strobe |-> (buf_we && buf_addr == LAST && rdy_bank == buf_bank));
endmodule

// File: rtl/pp_bank_status.sv
// Bank hand-off state. One held flag per bank, set by the ready strobe and
// cleared by a consumer release. Also the sticky overrun flag, set when a held
// bank starts to refill. Assumes a release and a strobe never target the same
// bank in the same cycle; if they do, the strobe wins.
module pp_bank_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rdy_strobe,
    input  logic       rdy_bank,
    input  logic       rel_valid,
    input  logic       rel_bank,
    input  logic       fill_start,
    input  logic       fill_bank,
    input  logic       overrun_clr,
    output logic [1:0] buf_ready,
    output logic       overrun
);
    genvar b;
    generate
        for (b = 0; b < 2; b++) begin : g_bank
            // Held flag of bank b.
            always_ff @(posedge clk) begin
                if (!rst_n)                                    buf_ready[b] <= 1'b0;
                else if (rdy_strobe && rdy_bank == 1'(b))      buf_ready[b] <= 1'b1;
                else if (rel_valid && rel_bank == 1'(b))       buf_ready[b] <= 1'b0;
            end
        end
    endgenerate

    logic hit;
    assign hit = fill_start && buf_ready[fill_bank] && !(rel_valid && rel_bank == fill_bank);

    // Sticky overrun; a new hit beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)           overrun <= 1'b0;
        else if (hit)         overrun <= 1'b1;
        else if (overrun_clr) overrun <= 1'b0;
    end

    // R8: a strobe leaves its bank held the next cycle
    a_r8_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_strobe |=> buf_ready[$past(rdy_bank)]);

    // R8: a release of a bank without a strobe leaves it free
    a_r8_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !rdy_strobe) |=> !buf_ready[$past(rel_bank)]);

    // R9: overrun holds until cleared
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !overrun_clr) |=> overrun);
endmodule

// File: rtl/pingpong_mover.sv
// Top: a half-full triggered FIFO drain into two alternating buffers.
// Buffers are FIFO_DEPTH/4 words each; one burst moves FIFO_DEPTH/2 words.
// Assumes a show-ahead FIFO and FIFO_DEPTH a power of two of at least 8.
module pingpong_mover
    import pp_pkg::*;
#(
    parameter int FIFO_DEPTH = DEF_FIFO_DEPTH,
    parameter int DATA_W     = DEF_DATA_W
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  rd_en,
    input  logic                                  fifo_half,
    input  logic                                  fifo_empty,
    input  logic [DATA_W-1:0]                     fifo_data,
    output logic                                  fifo_rd,
    output logic                                  buf_we,
    output logic                                  buf_bank,
    output logic [$clog2(FIFO_DEPTH/4)-1:0]       buf_addr,
    output logic [DATA_W-1:0]                     buf_wdata,
    output logic                                  rdy_strobe,
    output logic                                  rdy_bank,
    output logic [1:0]                            buf_ready,
    input  logic                                  rel_valid,
    input  logic                                  rel_bank,
    output logic                                  overrun,
    input  logic                                  overrun_clr
);
    localparam int BURST_WORDS = FIFO_DEPTH / 2;
    localparam int BUF_WORDS   = FIFO_DEPTH / 4;

    logic fill_start;
    logic fill_bank;

    pp_burst_ctrl #(.BURST_WORDS(BURST_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
        .fifo_half(fifo_half), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd)
    );

    pp_writer #(.DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)) u_wr (
        .clk(clk), .rst_n(rst_n), .fifo_rd(fifo_rd), .fifo_data(fifo_data),
        .buf_we(buf_we), .buf_bank(buf_bank), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .rdy_strobe(rdy_strobe), .rdy_bank(rdy_bank),
        .fill_start(fill_start), .fill_bank(fill_bank)
    );

    pp_bank_status u_stat (
        .clk(clk), .rst_n(rst_n), .rdy_strobe(rdy_strobe), .rdy_bank(rdy_bank),
        .rel_valid(rel_valid), .rel_bank(rel_bank), .fill_start(fill_start),
        .fill_bank(fill_bank), .overrun_clr(overrun_clr),
        .buf_ready(buf_ready), .overrun(overrun)
    );

    // R6: never pop an empty FIFO (checked at the top-level ports)
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);
endmodule

// File: tb/tb_pingpong_mover.sv
// Bench: small configuration (FIFO 32, buffers of 8, bursts of 16). A
// show-ahead FIFO model feeds indexed data; a monitor predicts each write.
module tb_pingpong_mover;
    localparam int FD   = 32;
    localparam int BW   = FD / 4;
    localparam int HALF = FD / 2;
    localparam int AW   = $clog2(BW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en = 1'b0;
    logic fifo_half, fifo_empty, fifo_rd;
    logic [15:0] fifo_data;
    logic buf_we, buf_bank, rdy_strobe, rdy_bank, overrun;
    logic [AW-1:0] buf_addr;
    logic [15:0] buf_wdata;
    logic [1:0] buf_ready;
    logic rel_valid = 1'b0, rel_bank = 1'b0, overrun_clr = 1'b0;

    int checks = 0, failures = 0;
    int wr_idx = 0, rd_idx = 0;
    logic force_half = 1'b0;
    int wseen = 0;
    int ea = 0;
    logic eb = 1'b0;
    logic [1:0] exp_ready = 2'b00;
    logic exp_ovr = 1'b0;
    bit done = 0;

    always #4 clk = ~clk;

    function automatic logic [15:0] word_of(int i);
        return 16'((i * 40503) ^ (i << 11) ^ 32'h5A3C);
    endfunction

    assign fifo_empty = (wr_idx == rd_idx);
    assign fifo_half  = force_half || ((wr_idx - rd_idx) >= HALF);
    assign fifo_data  = word_of(rd_idx);

    always @(posedge clk) if (fifo_rd) rd_idx <= rd_idx + 1;

    pingpong_mover #(.FIFO_DEPTH(FD), .DATA_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .fifo_half(fifo_half),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .buf_we(buf_we), .buf_bank(buf_bank), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .rdy_strobe(rdy_strobe), .rdy_bank(rdy_bank),
        .buf_ready(buf_ready), .rel_valid(rel_valid), .rel_bank(rel_bank),
        .overrun(overrun), .overrun_clr(overrun_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: predicts each write, strobe and overrun from the read order.
    always @(negedge clk) if (rst_n) begin
        if (fifo_rd) chk(!fifo_empty, "R6 pop while empty", 1, 0);
        if (buf_we) begin
            chk(buf_bank == eb, "R3 bank", int'(buf_bank), int'(eb));
            chk(int'(buf_addr) == ea, "R3 addr", int'(buf_addr), ea);
            chk(buf_wdata == word_of(wseen), "R3 data", int'(buf_wdata), int'(word_of(wseen)));
            if (ea == 0 && exp_ready[eb]) exp_ovr = 1'b1;
            if (ea == BW - 1) begin
                chk(rdy_strobe && rdy_bank == eb, "R4 strobe", int'(rdy_strobe), 1);
                exp_ready[eb] = 1'b1;
                ea = 0;
                eb = ~eb;
            end else begin
                chk(!rdy_strobe, "R4 early strobe", int'(rdy_strobe), 0);
                ea++;
            end
            wseen++;
        end else if (rdy_strobe) begin
            chk(1'b0, "R4 strobe without write", 1, 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int n);
        wr_idx += n;
    endtask

    task automatic release_bank(input logic b);
        rel_valid = 1'b1; rel_bank = b;
        cyc(1);
        rel_valid = 1'b0;
        exp_ready[b] = 1'b0;
        cyc(1);
    endtask

    initial begin
        int snap;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!fifo_rd && !buf_we && !rdy_strobe, "R1 strobes idle", int'({fifo_rd, buf_we, rdy_strobe}), 0);
        chk(buf_ready == 2'b00 && !overrun, "R1 flags clear", int'({buf_ready, overrun}), 0);

        // R2: half-full without enable starts nothing
        push(20);
        cyc(10);
        chk(rd_idx == 0, "R2 no read when disabled", rd_idx, 0);

        // R5: one burst moves exactly two buffers
        rd_en = 1'b1;
        cyc(40);
        chk(rd_idx == HALF, "R5 burst length", rd_idx, HALF);
        chk(buf_ready == 2'b11, "R8 both held", int'(buf_ready), 3);
        chk(wseen == HALF, "R1 writes from bank0 addr0", wseen, HALF);

        // R8: releases free each bank
        release_bank(1'b0);
        chk(buf_ready == 2'b10, "R8 release bank0", int'(buf_ready), 2);
        release_bank(1'b1);
        chk(buf_ready == 2'b00, "R8 release bank1", int'(buf_ready), 0);

        // R6: forced trigger with 4 words left stops at empty
        force_half = 1'b1;
        cyc(20);
        chk(rd_idx == 20, "R6 early stop", rd_idx, 20);
        force_half = 1'b0;
        cyc(2);

        // R2: below half-full, enabled, nothing moves
        push(12);
        cyc(20);
        chk(rd_idx == 20, "R2 no read below half", rd_idx, 20);

        // R7: disable mid-burst, then resume
        rd_en = 1'b0;
        push(18);
        cyc(5);
        chk(rd_idx == 20, "R7 idle while disabled", rd_idx, 20);
        rd_en = 1'b1;
        cyc(3);
        rd_en = 1'b0;
        snap = rd_idx;
        cyc(6);
        chk(rd_idx == snap && snap > 20, "R7 reads stop", rd_idx, snap);
        chk(wseen == snap, "R7 in-flight word written", wseen, snap);
        rd_en = 1'b1;
        cyc(40);
        chk(rd_idx == snap + HALF, "R7 resumed burst", rd_idx, snap + HALF);

        // R9: a held bank was re-entered during the resumed burst
        chk(exp_ovr == 1'b1 && overrun == 1'b1, "R9 overrun set", int'(overrun), 1);
        cyc(10);
        chk(overrun == 1'b1, "R9 overrun sticky", int'(overrun), 1);
        overrun_clr = 1'b1;
        cyc(1);
        overrun_clr = 1'b0;
        exp_ovr = 1'b0;
        cyc(1);
        chk(overrun == 1'b0, "R9 overrun cleared", int'(overrun), 0);
        chk(buf_ready == exp_ready, "R8 held flags", int'(buf_ready), int'(exp_ready));

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule